// File: doc/BRIEF.md
# Interrupt Dispatch and Low-Power Wake Sequencer

This block sits beside a small 8-bit processor core and makes one decision at every instruction boundary. The choices are to enter an interrupt service routine, to wake from a halted or stopped state, to stay idle, or to let the next instruction run. It also covers one special case: after a halt that was entered with an interrupt already waiting and interrupts masked, the next opcode byte is fetched a second time because the program counter does not advance. The core marks each boundary with a one-cycle `step` pulse, and for that cycle the block drives its decision outputs from combinational logic. Retired EI, DI, RETI, HALT and STOP instructions are reported on separate one-cycle strobes, and these update the block's state at the next clock edge.

Five interrupt sources are ranked by bit index, and bit 0 has the highest priority. A source counts as pending when both its request flag and its enable bit are set. When an interrupt is dispatched, the block gives the core the 16-bit service address and the index of the request flag that must be cleared. It also reports how many extra machine cycles the boundary consumed. The stack push and all bus traffic are handled by the core.

Top module: `irq_halt_seq`

## Requirements
- R1: After reset the master enable, halted and stopped outputs are 0, no delayed enable is waiting, and no dispatch is requested.
- R2: A source i is pending when req_flags[i] and req_enables[i] are both 1. When several sources are pending, the lowest index wins. disp_idx gives that index, and disp_vec equals 0x0040 + 8*index, so index 0 maps to 0x0040 and index 4 maps to 0x0060.
- R3: When step is 1, the master enable is on, the block is not stopped and a source is pending, disp_req is 1 and extra_mc is 5. The master enable reads 0 from the next cycle on.
- R4: A dispatch that wakes a halted core reports extra_mc = 6, and halted reads 0 from the next cycle on.
- R5: op_ei does not turn the master enable on by itself. The master enable turns on at the next step, and that step cannot dispatch. op_ei while the master enable is already on changes nothing.
- R6: op_di clears the master enable at the next edge and cancels a delayed enable that is still waiting. op_reti sets the master enable at the next edge.
- R7: While halted with the master enable off, a step that sees a pending source leaves halt without dispatching. It reports extra_mc = 1 and hold_pc = 0.
- R8: op_halt with the master enable off and a source pending arms a replay. The next step then asserts hold_pc, reports extra_mc = 1, does not dispatch and leaves halt. The step after that has hold_pc = 0.
- R9: A step while halted or stopped with no wake condition reports extra_mc = 1, changes no state and does not dispatch. While stopped, no dispatch occurs even with the master enable on and a source pending.
- R10: The stopped state ends only at a step with joy_wake = 1. That step reports extra_mc = 0 and does not dispatch.
- R11: When step is 0, disp_req, hold_pc and extra_mc are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_flags | input | 5 | Interrupt request flags, bit 0 has the highest priority |
| req_enables | input | 5 | Per-source enable bits |
| step | input | 1 | Instruction-boundary strobe |
| op_ei | input | 1 | EI retired |
| op_di | input | 1 | DI retired |
| op_reti | input | 1 | RETI retired |
| op_halt | input | 1 | HALT retired |
| op_stop | input | 1 | STOP retired |
| joy_wake | input | 1 | Joypad wake condition |
| ime | output | 1 | Master interrupt enable |
| disp_req | output | 1 | Dispatch an interrupt at this boundary |
| disp_vec | output | 16 | Service routine address |
| disp_idx | output | 3 | Index of the request flag to clear |
| halted | output | 1 | Core is halted |
| stopped | output | 1 | Core is stopped |
| hold_pc | output | 1 | Do not advance PC on this fetch |
| extra_mc | output | 3 | Extra machine cycles spent at this boundary |

## Verification
The assertions assume that the instruction strobes are mutually exclusive and never arrive in the same cycle as `step`, because a core retires at most one instruction between two boundaries. The bench follows this rule. It raises each strobe on its own for a single cycle, away from any boundary, and drives the request and enable vectors only between steps. The priority table is run with the master enable set by a RETI pulse just before each entry. Each directed sequence then starts from a known state built only from the block's own inputs.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int NUM_SRC     = 5;
  localparam int IDX_W       = $clog2(NUM_SRC);
  localparam int MC_W        = 3;
  localparam int VEC_W       = 16;
  localparam int DISPATCH_MC = 5;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0040;
  localparam logic [VEC_W-1:0] VEC_STEP = 16'h0008;

  typedef enum logic [1:0] {
    ACT_RUN      = 2'd0,
    ACT_DISPATCH = 2'd1,
    ACT_IDLE     = 2'd2,
    ACT_REPLAY   = 2'd3
  } act_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = irq_seq_pkg::NUM_SRC,
  parameter int IDX_W = irq_seq_pkg::IDX_W
) (
  input  logic [N-1:0]     flags,
  input  logic [N-1:0]     enables,
  output logic             pend,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] masked;

  assign masked = flags & enables;
  assign pend   = |masked;

  // walk downward so the lowest set bit is the last one written
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (masked[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
  parameter int IDX_W = irq_seq_pkg::IDX_W,
  parameter int VEC_W = irq_seq_pkg::VEC_W,
  parameter logic [VEC_W-1:0] BASE = irq_seq_pkg::VEC_BASE,
  parameter logic [VEC_W-1:0] STEP = irq_seq_pkg::VEC_STEP
) (
  input  logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] vec
);
  assign vec = BASE + VEC_W'(idx) * STEP;
endmodule

// File: rtl/irq_step_ctl.sv
module irq_step_ctl
  import irq_seq_pkg::*;
#(
  parameter int MC_W   = irq_seq_pkg::MC_W,
  parameter int DISP_MC = irq_seq_pkg::DISPATCH_MC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            pend,
  input  logic            op_ei,
  input  logic            op_di,
  input  logic            op_reti,
  input  logic            op_halt,
  input  logic            op_stop,
  input  logic            joy_wake,
  output logic            ime,
  output logic            halted,
  output logic            stopped,
  output logic            disp_req,
  output logic            hold_pc,
  output logic [MC_W-1:0] extra_mc
);
  logic ime_q, ime_d;
  logic eip_q, eip_d;
  logic hlt_q, hlt_d;
  logic stp_q, stp_d;
  logic bug_q, bug_d;
  logic upd_en;
  act_e act;
  logic [MC_W-1:0] extra;

  assign upd_en = step | op_ei | op_di | op_reti | op_halt | op_stop;

  always_comb begin
    ime_d = ime_q;
    eip_d = eip_q;
    hlt_d = hlt_q;
    stp_d = stp_q;
    bug_d = bug_q;
    act   = ACT_RUN;
    extra = '0;
    if (step) begin
      if (ime_q && !stp_q && pend) begin
        act   = ACT_DISPATCH;
        extra = MC_W'(DISP_MC) + MC_W'(hlt_q);
        hlt_d = 1'b0;
        bug_d = 1'b0;
        ime_d = 1'b0;
      end else if (ime_q && !stp_q && hlt_q) begin
        act   = ACT_IDLE;
        extra = MC_W'(1);
      end else if (hlt_q && bug_q) begin
        act   = ACT_REPLAY;
        extra = MC_W'(1);
        hlt_d = 1'b0;
        bug_d = 1'b0;
      end else if (hlt_q && pend) begin
        extra = MC_W'(1);
        hlt_d = 1'b0;
      end else if (stp_q && joy_wake) begin
        stp_d = 1'b0;
      end else if (hlt_q || stp_q) begin
        act   = ACT_IDLE;
        extra = MC_W'(1);
      end
      if (eip_q) begin
        ime_d = 1'b1;
        eip_d = 1'b0;
      end
    end
    if (op_ei && !ime_q) eip_d = 1'b1;
    if (op_di) begin
      ime_d = 1'b0;
      eip_d = 1'b0;
    end
    if (op_reti) ime_d = 1'b1;
    if (op_halt) begin
      hlt_d = 1'b1;
      bug_d = !ime_q && pend;
    end
    if (op_stop) stp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime_q <= 1'b0;
      eip_q <= 1'b0;
      hlt_q <= 1'b0;
      stp_q <= 1'b0;
      bug_q <= 1'b0;
    end else if (upd_en) begin
      ime_q <= ime_d;
      eip_q <= eip_d;
      hlt_q <= hlt_d;
      stp_q <= stp_d;
      bug_q <= bug_d;
    end
  end

  assign ime      = ime_q;
  assign halted   = hlt_q;
  assign stopped  = stp_q;
  assign disp_req = (act == ACT_DISPATCH);
  assign hold_pc  = (act == ACT_REPLAY);
  assign extra_mc = extra;
endmodule

// File: rtl/irq_halt_seq.sv
module irq_halt_seq
  import irq_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_flags,
  input  logic [NUM_SRC-1:0] req_enables,
  input  logic               step,
  input  logic               op_ei,
  input  logic               op_di,
  input  logic               op_reti,
  input  logic               op_halt,
  input  logic               op_stop,
  input  logic               joy_wake,
  output logic               ime,
  output logic               disp_req,
  output logic [VEC_W-1:0]   disp_vec,
  output logic [IDX_W-1:0]   disp_idx,
  output logic               halted,
  output logic               stopped,
  output logic               hold_pc,
  output logic [MC_W-1:0]    extra_mc
);
  logic             rst_meta_n;
  logic             rst_sync_n;
  logic             pend;
  logic [IDX_W-1:0] win_idx;
  logic [VEC_W-1:0] win_vec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  irq_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .flags   (req_flags),
    .enables (req_enables),
    .pend    (pend),
    .idx     (win_idx)
  );

  irq_vec_map #(.IDX_W(IDX_W), .VEC_W(VEC_W), .BASE(VEC_BASE), .STEP(VEC_STEP)) u_vec (
    .idx (win_idx),
    .vec (win_vec)
  );

  irq_step_ctl #(.MC_W(MC_W), .DISP_MC(DISPATCH_MC)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (step),
    .pend     (pend),
    .op_ei    (op_ei),
    .op_di    (op_di),
    .op_reti  (op_reti),
    .op_halt  (op_halt),
    .op_stop  (op_stop),
    .joy_wake (joy_wake),
    .ime      (ime),
    .halted   (halted),
    .stopped  (stopped),
    .disp_req (disp_req),
    .hold_pc  (hold_pc),
    .extra_mc (extra_mc)
  );

  assign disp_vec = disp_req ? win_vec : '0;
  assign disp_idx = disp_req ? win_idx : '0;
endmodule

// File: rtl/irq_halt_seq_chk.sv
module irq_halt_seq_chk
  import irq_seq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_flags,
  input logic [NUM_SRC-1:0] req_enables,
  input logic               step,
  input logic               op_ei,
  input logic               op_di,
  input logic               op_reti,
  input logic               joy_wake,
  input logic               ime,
  input logic               disp_req,
  input logic [IDX_W-1:0]   disp_idx,
  input logic               halted,
  input logic               stopped,
  input logic               hold_pc,
  input logic [MC_W-1:0]    extra_mc
);
  logic [NUM_SRC-1:0] sel_bit;
  assign sel_bit = NUM_SRC'(1) << disp_idx;

  AST_DISP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    disp_req |-> (step && ime && !stopped)); // R3
  AST_DISP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_req |-> |(req_flags & req_enables & sel_bit)); // R2
  AST_DISP_DROPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
    disp_req |=> !ime); // R3
  AST_EI_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ei && !ime && !step && !op_reti) |=> !ime); // R5
  AST_DI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op_di |=> !ime); // R6
  AST_RETI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_reti && !op_di) |=> ime); // R6
  AST_REPLAY_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pc |=> !halted); // R8
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && stopped && !joy_wake) |=> stopped); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> (!disp_req && !hold_pc && extra_mc == '0)); // R11
endmodule

bind irq_halt_seq irq_halt_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_flags   (req_flags),
  .req_enables (req_enables),
  .step        (step),
  .op_ei       (op_ei),
  .op_di       (op_di),
  .op_reti     (op_reti),
  .joy_wake    (joy_wake),
  .ime         (ime),
  .disp_req    (disp_req),
  .disp_idx    (disp_idx),
  .halted      (halted),
  .stopped     (stopped),
  .hold_pc     (hold_pc),
  .extra_mc    (extra_mc)
);

// File: tb/test_irq_halt_seq.sv
module test_irq_halt_seq;
  logic        clk;
  logic        rst_n;
  logic [4:0]  req_flags;
  logic [4:0]  req_enables;
  logic        step, op_ei, op_di, op_reti, op_halt, op_stop, joy_wake;
  logic        ime, disp_req, halted, stopped, hold_pc;
  logic [15:0] disp_vec;
  logic [2:0]  disp_idx;
  logic [2:0]  extra_mc;

  int checks = 0;
  int errors = 0;

  // {flags, enables, expect dispatch, expected index}
  localparam logic [13:0] TBL [8] = '{
    {5'h1F, 5'h1F, 1'b1, 3'd0},
    {5'h1E, 5'h1F, 1'b1, 3'd1},
    {5'h10, 5'h10, 1'b1, 3'd4},
    {5'h0C, 5'h08, 1'b1, 3'd3},
    {5'h0F, 5'h00, 1'b0, 3'd0},
    {5'h14, 5'h04, 1'b1, 3'd2},
    {5'h00, 5'h1F, 1'b0, 3'd0},
    {5'h18, 5'h1F, 1'b1, 3'd3}
  };

  irq_halt_seq i_irq_halt_seq (
    .clk(clk), .rst_n(rst_n), .req_flags(req_flags), .req_enables(req_enables),
    .step(step), .op_ei(op_ei), .op_di(op_di), .op_reti(op_reti),
    .op_halt(op_halt), .op_stop(op_stop), .joy_wake(joy_wake),
    .ime(ime), .disp_req(disp_req), .disp_vec(disp_vec), .disp_idx(disp_idx),
    .halted(halted), .stopped(stopped), .hold_pc(hold_pc), .extra_mc(extra_mc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk_state(input logic e_ime, input logic e_hlt, input logic e_stp,
                           input string tag);
    checks++;
    if ({ime, halted, stopped} !== {e_ime, e_hlt, e_stp}) begin
      errors++;
      $display("FAIL %s ime/halted/stopped got %b%b%b exp %b%b%b", tag,
               ime, halted, stopped, e_ime, e_hlt, e_stp);
    end
  endtask

  task automatic do_step(input logic e_req, input logic [2:0] e_idx, input logic [2:0] e_mc,
                         input logic e_hold, input string tag);
    logic [15:0] e_vec;
    e_vec = e_req ? (16'h0040 + 16'(e_idx) * 16'd8) : 16'h0000;
    @(negedge clk);
    step = 1'b1;
    #1;
    checks++;
    if ({disp_req, hold_pc, extra_mc, disp_idx, disp_vec} !==
        {e_req, e_hold, e_mc, (e_req ? e_idx : 3'd0), e_vec}) begin
      errors++;
      $display("FAIL %s req/hold/mc/idx/vec got %b %b %0d %0d %h exp %b %b %0d %0d %h",
               tag, disp_req, hold_pc, extra_mc, disp_idx, disp_vec,
               e_req, e_hold, e_mc, e_idx, e_vec);
    end
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: op_ei = 1'b1;
      1: op_di = 1'b1;
      2: op_reti = 1'b1;
      3: op_halt = 1'b1;
      default: op_stop = 1'b1;
    endcase
    @(negedge clk);
    {op_ei, op_di, op_reti, op_halt, op_stop} = '0;
  endtask

  task automatic set_req(input logic [4:0] f, input logic [4:0] e);
    @(negedge clk);
    req_flags = f;
    req_enables = e;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {req_flags, req_enables} = '0;
    {step, op_ei, op_di, op_reti, op_halt, op_stop, joy_wake} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk_state(1'b0, 1'b0, 1'b0, "R1 reset");
    do_step(1'b0, 3'd0, 3'd0, 1'b0, "R1 reset step");

    // R2 R3 priority table, master enable set by RETI before each entry
    for (int k = 0; k < 8; k++) begin
      set_req(TBL[k][13:9], TBL[k][8:4]);
      pulse(2);
      do_step(TBL[k][3], TBL[k][2:0], TBL[k][3] ? 3'd5 : 3'd0, 1'b0,
              $sformatf("R2 R3 entry %0d", k));
      chk_state(!TBL[k][3], 1'b0, 1'b0, $sformatf("R3 ime after entry %0d", k));
    end

    // R11 no step, nothing driven
    pulse(2);
    set_req(5'h01, 5'h01);
    #1;
    checks++;
    if ({disp_req, hold_pc, extra_mc} !== 5'b0) begin
      errors++;
      $display("FAIL R11 outputs without step got %b%b%0d exp 000", disp_req, hold_pc, extra_mc);
    end
    pulse(1);
    chk_state(1'b0, 1'b0, 1'b0, "R6 DI clears");
    do_step(1'b0, 3'd0, 3'd0, 1'b0, "R6 no dispatch after DI");

    // R5 delayed enable
    pulse(0);
    chk_state(1'b0, 1'b0, 1'b0, "R5 EI not immediate");
    do_step(1'b0, 3'd0, 3'd0, 1'b0, "R5 step after EI runs");
    chk_state(1'b1, 1'b0, 1'b0, "R5 enable after step");
    pulse(0);
    do_step(1'b1, 3'd0, 3'd5, 1'b0, "R5 EI while on, dispatch");

    // R6 DI cancels waiting EI
    pulse(0);
    pulse(1);
    do_step(1'b0, 3'd0, 3'd0, 1'b0, "R6 cancel step1");
    do_step(1'b0, 3'd0, 3'd0, 1'b0, "R6 cancel step2");
    chk_state(1'b0, 1'b0, 1'b0, "R6 EI cancelled");

    // R9 R7 halt with master enable off, wake on request
    set_req(5'h00, 5'h1F);
    pulse(3);
    chk_state(1'b0, 1'b1, 1'b0, "R9 halted");
    do_step(1'b0, 3'd0, 3'd1, 1'b0, "R9 halted idle");
    chk_state(1'b0, 1'b1, 1'b0, "R9 still halted");
    set_req(5'h04, 5'h1F);
    do_step(1'b0, 3'd0, 3'd1, 1'b0, "R7 wake no dispatch");
    chk_state(1'b0, 1'b0, 1'b0, "R7 left halt");

    // R8 replay
    pulse(3);
    do_step(1'b0, 3'd0, 3'd1, 1'b1, "R8 replay step");
    chk_state(1'b0, 1'b0, 1'b0, "R8 left halt");
    do_step(1'b0, 3'd0, 3'd0, 1'b0, "R8 following step");

    // R4 halt with master enable on
    set_req(5'h00, 5'h1F);
    pulse(2);
    pulse(3);
    do_step(1'b0, 3'd0, 3'd1, 1'b0, "R9 halted ime on idle");
    set_req(5'h08, 5'h1F);
    do_step(1'b1, 3'd3, 3'd6, 1'b0, "R4 dispatch from halt");
    chk_state(1'b0, 1'b0, 1'b0, "R4 halt cleared");

    // R9 R10 stop
    pulse(2);
    pulse(4);
    chk_state(1'b1, 1'b0, 1'b1, "R10 stopped");
    do_step(1'b0, 3'd0, 3'd1, 1'b0, "R9 no dispatch while stopped");
    chk_state(1'b1, 1'b0, 1'b1, "R10 stays stopped");
    @(negedge clk);
    joy_wake = 1'b1;
    do_step(1'b0, 3'd0, 3'd0, 1'b0, "R10 joypad wake");
    joy_wake = 1'b0;
    chk_state(1'b1, 1'b0, 1'b0, "R10 left stop");
    do_step(1'b1, 3'd3, 3'd5, 1'b0, "R3 dispatch after stop");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule